// File: doc/BRIEF.md
# Receive-channel FIFO manager for chain restarts

This block sits between a peripheral and the memory writer of a peripheral-to-memory DMA channel. It owns the channel's data FIFO. While a descriptor chain runs, the FIFO passes peripheral items to the memory side in arrival order. When a work unit finishes with its flow mode set to stop, the channel pauses. During the pause the memory side is starved, but the peripheral may still deposit items. When a work unit ends without the stop flag, nothing changes and the stream goes on.

The pause ends on a restart strobe, which is the configuration write that starts the next chain. The first descriptor of that chain brings a sync flag and an element size, and the flag picks how the held items are treated. With sync set, every item that entered before the restart strobe is thrown away, and only later items reach memory. In that case any element size is allowed. With sync clear, the held items are kept and are the first items written to memory. This is only legal when the element size matches the previous chain's. A mismatch raises a sticky error and the channel stays paused.

Dropping the channel enable empties the FIFO, forgets the stored element size and clears the error.

Top module: `rx_restart_fifo`

## Requirements
- R1: After reset, and in the cycle after the channel enable is low, `running`, `memValid`, `periphReady` and `sizeErr` are all 0.
- R2: While running, items leave on `memData` in the order they were accepted. `memValid` is 1 exactly when at least one item is held, and an item is consumed on a cycle with `memValid` and `memReady` both 1.
- R3: A work-unit end with the stop flag clear leaves the channel running and keeps all held items.
- R4: A work-unit end with the stop flag set pauses the channel. While paused, `memValid` stays 0 and peripheral items are still accepted.
- R5: When DEPTH items are held, `periphReady` is 0. A refused write stores nothing, and no held item is overwritten.
- R6: A restart from pause with sync = 1 discards every item accepted before the restart cycle and accepts any element size. An item accepted in the restart cycle itself is kept.
- R7: A restart from pause with sync = 0 and an unchanged element size resumes, and the held items come out first, in their original order.
- R8: A restart from pause with sync = 0 and a different element size sets `sizeErr` and leaves the channel paused with its items held. While `sizeErr` is 1, all restarts are refused, and the flag holds until the enable drops.
- R9: Disabling the channel discards held items and the stored element size. The first restart after re-enabling is accepted with any size and sync value and starts with an empty FIFO.
- R10: A restart strobe has no effect while the channel is running or while the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | 1 | Channel enable; low clears the FIFO, the stored size and the error |
| periphValid | input | 1 | Peripheral offers an item |
| periphData | input | DW | Peripheral item |
| periphReady | output | 1 | Item accepted this cycle if `periphValid` is 1 |
| unitDone | input | 1 | Pulse: current work unit finished |
| unitStop | input | 1 | Flow mode of the finished unit was stop |
| restartStb | input | 1 | Pulse: configuration write starting a new chain |
| descSync | input | 1 | Sync flag of the new chain's first descriptor |
| descSize | input | SW | Element-size code of the new chain |
| memValid | output | 1 | Head item available to the memory writer |
| memData | output | DW | Head item |
| memReady | input | 1 | Memory writer takes the head item |
| running | output | 1 | Channel is running (not off, not paused) |
| sizeErr | output | 1 | Sticky illegal element-size change |

## Verification
The embedded properties assume that `unitDone` only pulses while the channel runs, and that `restartStb` is a single-cycle strobe whose descriptor fields are valid in the same cycle. The stimulus keeps to these assumptions. It raises each strobe for exactly one cycle, between negative edges, and it only sends unit ends after a restart has been accepted. Peripheral writes are offered while the FIFO is full on purpose, to show that the refusal stores nothing. Every other input combination stays inside the handshake rules.

// File: rtl/rx_restart_pkg.sv
package rx_restart_pkg;

  // Strobes from the controller to the storage
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoCmd_t;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } chanState_t;

endpackage

// File: rtl/rx_restart_store.sv
module rx_restart_store
  import rx_restart_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoCmd_t      cmd,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          full,
  output logic          empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr, wrAddr;
  logic [CW-1:0] count;

  // A flush restarts both pointers at slot 0, so a write in the same cycle lands there
  assign wrAddr = cmd.flush ? '0 : wrPtr;

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (cmd.flush) begin
      rdPtr <= '0;
      wrPtr <= cmd.push ? AW'(1) : '0;
      count <= cmd.push ? CW'(1) : '0;
    end else begin
      if (cmd.push) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      if (cmd.pop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + AW'(1);
      case ({cmd.push, cmd.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN) cmd.push |-> (!full || cmd.flush)); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN) count <= CW'(DEPTH)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN) cmd.pop |-> !empty); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN) (cmd.flush && !cmd.push) |=> empty); // R6

endmodule

// File: rtl/rx_restart_ctrl.sv
module rx_restart_ctrl
  import rx_restart_pkg::*;
#(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          chanEn,
  input  logic          periphValid,
  input  logic          unitDone,
  input  logic          unitStop,
  input  logic          restartStb,
  input  logic          descSync,
  input  logic [SW-1:0] descSize,
  input  logic          memReady,
  input  logic          fifoFull,
  input  logic          fifoEmpty,
  output fifoCmd_t      cmd,
  output logic          periphReady,
  output logic          memValid,
  output logic          running,
  output logic          sizeErr
);

  chanState_t    state, stateNext;
  logic [SW-1:0] prevSize, prevSizeNext;
  logic          prevValid, prevValidNext;
  logic          errQ, errNext;
  logic          flushNow;

  always_comb begin
    stateNext     = state;
    prevSizeNext  = prevSize;
    prevValidNext = prevValid;
    errNext       = errQ;
    flushNow      = 1'b0;
    if (!chanEn) begin
      stateNext     = ST_OFF;
      prevValidNext = 1'b0;
      errNext       = 1'b0;
      flushNow      = 1'b1;
    end else begin
      case (state)
        ST_OFF: begin
          if (restartStb) begin
            stateNext     = ST_RUN;
            prevSizeNext  = descSize;
            prevValidNext = 1'b1;
          end
        end
        ST_RUN: begin
          if (unitDone && unitStop) stateNext = ST_PAUSE;
        end
        ST_PAUSE: begin
          if (restartStb && !errQ) begin
            if (descSync) begin
              flushNow      = 1'b1;
              stateNext     = ST_RUN;
              prevSizeNext  = descSize;
              prevValidNext = 1'b1;
            end else if (!prevValid || (descSize == prevSize)) begin
              stateNext     = ST_RUN;
              prevSizeNext  = descSize;
              prevValidNext = 1'b1;
            end else begin
              errNext = 1'b1;
            end
          end
        end
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_OFF;
      prevSize  <= '0;
      prevValid <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      state     <= stateNext;
      prevSize  <= prevSizeNext;
      prevValid <= prevValidNext;
      errQ      <= errNext;
    end
  end

  assign periphReady = chanEn && (state != ST_OFF) && !fifoFull;
  assign memValid    = chanEn && (state == ST_RUN) && !fifoEmpty;
  assign running     = (state == ST_RUN);
  assign sizeErr     = errQ;

  assign cmd.push  = periphValid && periphReady;
  assign cmd.pop   = memValid && memReady;
  assign cmd.flush = flushNow;

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rstN) !chanEn |=> (!running && !sizeErr)); // R1
  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rstN) !running |-> !memValid); // R4
  AST_STOP_PAUSES: assert property (@(posedge clk) disable iff (!rstN) (chanEn && running && unitDone && unitStop) |=> !running); // R4
  AST_NOSTOP_RUNS: assert property (@(posedge clk) disable iff (!rstN) (chanEn && running && unitDone && !unitStop) |=> running); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN) (sizeErr && chanEn) |=> sizeErr); // R8
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rstN) sizeErr |-> !running); // R8
  AST_RUN_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rstN) (chanEn && running && !unitDone) |=> running); // R10

endmodule

// File: rtl/rx_restart_fifo.sv
module rx_restart_fifo
  import rx_restart_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int SW    = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          chanEn,
  input  logic          periphValid,
  input  logic [DW-1:0] periphData,
  output logic          periphReady,
  input  logic          unitDone,
  input  logic          unitStop,
  input  logic          restartStb,
  input  logic          descSync,
  input  logic [SW-1:0] descSize,
  output logic          memValid,
  output logic [DW-1:0] memData,
  input  logic          memReady,
  output logic          running,
  output logic          sizeErr
);

  fifoCmd_t cmd;
  logic     fifoFull, fifoEmpty;

  rx_restart_ctrl #(.SW(SW)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .chanEn      (chanEn),
    .periphValid (periphValid),
    .unitDone    (unitDone),
    .unitStop    (unitStop),
    .restartStb  (restartStb),
    .descSync    (descSync),
    .descSize    (descSize),
    .memReady    (memReady),
    .fifoFull    (fifoFull),
    .fifoEmpty   (fifoEmpty),
    .cmd         (cmd),
    .periphReady (periphReady),
    .memValid    (memValid),
    .running     (running),
    .sizeErr     (sizeErr)
  );

  rx_restart_store #(.DW(DW), .DEPTH(DEPTH)) uStore (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .wrData (periphData),
    .rdData (memData),
    .full   (fifoFull),
    .empty  (fifoEmpty)
  );

endmodule

// File: tb/tb_rx_restart_fifo.sv
module tb_rx_restart_fifo;

  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int SW = 2;

  // Vector: {req[3:0], op[2:0], arg[7:0], sync, size[1:0]}
  // op 0 push arg, 1 unit end (sync field = stop), 2 restart, 3 pop expecting arg,
  // 4 status check arg[3:0] = {running, sizeErr, memValid, periphReady}, 5 enable = arg[0]
  localparam int NV = 52;
  localparam logic [17:0] VEC [NV] = '{
    {4'd1, 3'd5, 8'h01, 1'b0, 2'd0},
    {4'd1, 3'd4, 8'h00, 1'b0, 2'd0},  // R1 enabled but not started
    {4'd2, 3'd2, 8'h00, 1'b0, 2'd1},
    {4'd2, 3'd4, 8'h09, 1'b0, 2'd0},  // R2
    {4'd2, 3'd0, 8'h11, 1'b0, 2'd0},
    {4'd2, 3'd0, 8'h12, 1'b0, 2'd0},
    {4'd2, 3'd3, 8'h11, 1'b0, 2'd0},  // R2
    {4'd3, 3'd1, 8'h00, 1'b0, 2'd0},
    {4'd3, 3'd4, 8'h0B, 1'b0, 2'd0},  // R3
    {4'd3, 3'd3, 8'h12, 1'b0, 2'd0},  // R3
    {4'd4, 3'd1, 8'h00, 1'b1, 2'd0},
    {4'd4, 3'd4, 8'h01, 1'b0, 2'd0},  // R4
    {4'd4, 3'd0, 8'h21, 1'b0, 2'd0},
    {4'd4, 3'd0, 8'h22, 1'b0, 2'd0},
    {4'd4, 3'd4, 8'h01, 1'b0, 2'd0},  // R4
    {4'd7, 3'd2, 8'h00, 1'b0, 2'd1},
    {4'd7, 3'd3, 8'h21, 1'b0, 2'd0},  // R7
    {4'd7, 3'd3, 8'h22, 1'b0, 2'd0},  // R7
    {4'd6, 3'd1, 8'h00, 1'b1, 2'd0},
    {4'd6, 3'd0, 8'h31, 1'b0, 2'd0},
    {4'd6, 3'd0, 8'h32, 1'b0, 2'd0},
    {4'd6, 3'd2, 8'h00, 1'b1, 2'd2},
    {4'd6, 3'd4, 8'h09, 1'b0, 2'd0},  // R6
    {4'd6, 3'd0, 8'h33, 1'b0, 2'd0},
    {4'd6, 3'd3, 8'h33, 1'b0, 2'd0},  // R6
    {4'd8, 3'd1, 8'h00, 1'b1, 2'd0},
    {4'd8, 3'd0, 8'h41, 1'b0, 2'd0},
    {4'd8, 3'd2, 8'h00, 1'b0, 2'd3},
    {4'd8, 3'd4, 8'h05, 1'b0, 2'd0},  // R8
    {4'd8, 3'd2, 8'h00, 1'b0, 2'd2},
    {4'd8, 3'd4, 8'h05, 1'b0, 2'd0},  // R8
    {4'd9, 3'd5, 8'h00, 1'b0, 2'd0},
    {4'd9, 3'd4, 8'h00, 1'b0, 2'd0},  // R9
    {4'd9, 3'd5, 8'h01, 1'b0, 2'd0},
    {4'd9, 3'd2, 8'h00, 1'b0, 2'd0},
    {4'd9, 3'd4, 8'h09, 1'b0, 2'd0},  // R9
    {4'd10, 3'd0, 8'h51, 1'b0, 2'd0},
    {4'd10, 3'd2, 8'h00, 1'b1, 2'd3},
    {4'd10, 3'd3, 8'h51, 1'b0, 2'd0}, // R10
    {4'd5, 3'd1, 8'h00, 1'b1, 2'd0},
    {4'd5, 3'd0, 8'h61, 1'b0, 2'd0},
    {4'd5, 3'd0, 8'h62, 1'b0, 2'd0},
    {4'd5, 3'd0, 8'h63, 1'b0, 2'd0},
    {4'd5, 3'd0, 8'h64, 1'b0, 2'd0},
    {4'd5, 3'd4, 8'h00, 1'b0, 2'd0},  // R5
    {4'd5, 3'd0, 8'h65, 1'b0, 2'd0},
    {4'd5, 3'd2, 8'h00, 1'b0, 2'd0},
    {4'd5, 3'd3, 8'h61, 1'b0, 2'd0},  // R5
    {4'd5, 3'd3, 8'h62, 1'b0, 2'd0},
    {4'd5, 3'd3, 8'h63, 1'b0, 2'd0},
    {4'd5, 3'd3, 8'h64, 1'b0, 2'd0},
    {4'd5, 3'd4, 8'h09, 1'b0, 2'd0}   // R5
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          chanEn = 1'b0;
  logic          periphValid = 1'b0;
  logic [DW-1:0] periphData = '0;
  logic          periphReady;
  logic          unitDone = 1'b0;
  logic          unitStop = 1'b0;
  logic          restartStb = 1'b0;
  logic          descSync = 1'b0;
  logic [SW-1:0] descSize = '0;
  logic          memValid;
  logic [DW-1:0] memData;
  logic          memReady = 1'b0;
  logic          running;
  logic          sizeErr;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_restart_fifo #(.DW(DW), .DEPTH(DEPTH), .SW(SW)) dut (
    .clk (clk), .rstN (rstN), .chanEn (chanEn),
    .periphValid (periphValid), .periphData (periphData), .periphReady (periphReady),
    .unitDone (unitDone), .unitStop (unitStop),
    .restartStb (restartStb), .descSync (descSync), .descSize (descSize),
    .memValid (memValid), .memData (memData), .memReady (memReady),
    .running (running), .sizeErr (sizeErr)
  );

  task automatic check(input int req, input string what, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic checkStatus(input int req, input logic [3:0] exp);
    check(req, "status {run,err,mv,rdy}", {4'b0, running, sizeErr, memValid, periphReady}, {4'b0, exp});
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doPush(input logic [7:0] d);
    periphValid = 1'b1; periphData = d;
    tick();
    periphValid = 1'b0;
  endtask

  task automatic doUnit(input logic stop);
    unitDone = 1'b1; unitStop = stop;
    tick();
    unitDone = 1'b0; unitStop = 1'b0;
  endtask

  task automatic doRestart(input logic s, input logic [1:0] z);
    restartStb = 1'b1; descSync = s; descSize = z;
    tick();
    restartStb = 1'b0; descSync = 1'b0;
  endtask

  task automatic doPop(input int req, input logic [7:0] exp);
    check(req, "memValid before pop", {7'b0, memValid}, 8'h01);
    check(req, "memData", memData, exp);
    memReady = 1'b1;
    tick();
    memReady = 1'b0;
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    @(negedge clk);
    tick();
    checkStatus(1, 4'b0000); // R1 in reset
    rstN = 1'b1;
    tick();
    checkStatus(1, 4'b0000); // R1 after reset

    for (int i = 0; i < NV; i++) begin
      logic [3:0] req;
      logic [2:0] op;
      logic [7:0] arg;
      logic       s;
      logic [1:0] z;
      {req, op, arg, s, z} = VEC[i];
      case (op)
        3'd0: doPush(arg);
        3'd1: doUnit(s);
        3'd2: doRestart(s, z);
        3'd3: doPop(int'(req), arg);
        3'd4: checkStatus(int'(req), arg[3:0]);
        default: begin chanEn = arg[0]; tick(); end
      endcase
    end

    // R6: an item arriving in the restart cycle survives the flush
    doUnit(1'b1);
    doPush(8'h71);
    periphValid = 1'b1; periphData = 8'h72;
    restartStb = 1'b1; descSync = 1'b1; descSize = 2'd1;
    tick();
    periphValid = 1'b0; restartStb = 1'b0; descSync = 1'b0;
    doPop(6, 8'h72);
    checkStatus(6, 4'b1001); // R6 older item gone

    // R10: restart while disabled does nothing
    chanEn = 1'b0;
    tick();
    doRestart(1'b0, 2'd0);
    checkStatus(10, 4'b0000); // R10

    // R1: reset mid-run returns to idle
    chanEn = 1'b1;
    doRestart(1'b0, 2'd0);
    doPush(8'h81);
    checkStatus(2, 4'b1011); // R2 item visible
    rstN = 1'b0;
    tick();
    checkStatus(1, 4'b0000); // R1
    rstN = 1'b1;
    tick();
    checkStatus(1, 4'b0000); // R1 stays off until restart

    done = 1'b1;
    finishRun();
  end

endmodule